// File: doc/BRIEF.md
# Calibration Job Chain Sequencer

This controller steps through a linked chain of calibration jobs and drives a measurement engine through each of them. A job is described by a one-hot type bit, a target number of sub-samples and the index of the job that follows it. For the job under the cursor, the sequencer starts the engine and waits for its busy flag to drop. Each time the flag drops it pulses a collect strobe. It then either starts another sub-sample or, once the target is reached, emits a post-process strobe tagged with the number of active receive chains. The measurement arithmetic itself is not part of the block.

Finished jobs set their type bit in a validity mask held for the current channel. A job whose bit is already set in that mask is passed over without being run. When a job finishes and the job after it is still waiting, the sequencer starts that next job in the same step, so the done level never rises between the two. A separate long-interval tick produces a noise-floor load strobe followed by a noise-floor start strobe. This path does not depend on where the job chain is.

Top module: `cal_list_seq`

## Requirements
- R1: Out of reset there is no current job. `done_o` is 1, every strobe output is 0 and `valid_mask_o` is 0.
- R2: A cycle with `init_i` high makes job `head_i` current, provided `list_en_i` is 1. It puts every job in the waiting state and loads `valid_mask_o` from `chan_valid_i`. In the following cycle `done_o` equals the inverse of `list_en_i`.
- R3: A current waiting job whose type bit is clear in the mask gets a start pulse one cycle later. Its sample counter is cleared and it becomes running.
- R4: A running job produces one collect pulse, and its counter goes up by one, in a cycle where `engine_busy_i` is low and `start_o` is not high. The engine must raise busy in the cycle after a start pulse.
- R5: After a collect, a new start pulse is issued while the count is below the job's target. When the count reaches the target, `post_o` rises together with `collect_o`, and `post_chains_o` carries the number of set bits in the 3-bit `rx_mask_i`. A target of 0 behaves as 1.
- R6: A finishing job ORs its type bit into `valid_mask_o` and becomes done. Mask bits are only cleared by `init_i`.
- R7: A current waiting job whose type bit is already set is skipped. It becomes done with no start, collect or post, and the cursor moves to its next job.
- R8: When a job finishes and its next job is waiting with its type bit clear, the next job is started in the same step. `done_o` stays low from the init until the last job in the chain finishes.
- R9: `done_o` is high exactly when there is no current job or the current job is done. No start pulse is issued while there is no current job.
- R10: A rising `nf_tick_i` yields `nf_load_o` one cycle later and `nf_start_o` the cycle after that, whatever the job chain is doing.
- R11: `start_o`, `collect_o`, `post_o`, `nf_load_o` and `nf_start_o` are never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load the chain head and the channel mask, and mark all jobs waiting |
| head_i | input | IDX_W | Index of the first job |
| list_en_i | input | 1 | Chain holds at least one job |
| chan_valid_i | input | TYPE_W | Channel validity mask loaded at init |
| job_type_i | input | NUM_JOBS x TYPE_W | One-hot type bit of each job |
| job_target_i | input | NUM_JOBS x CNT_W | Sub-sample target of each job |
| job_next_i | input | NUM_JOBS x IDX_W | Index of the following job |
| engine_busy_i | input | 1 | Measurement engine busy |
| rx_mask_i | input | CHAINS | Active receive chains |
| nf_tick_i | input | 1 | Long-interval tick |
| start_o | output | 1 | Engine start pulse |
| collect_o | output | 1 | Collect pulse |
| post_o | output | 1 | Post-process pulse |
| post_chains_o | output | CHW | Active chain count sent with the post pulse |
| nf_load_o | output | 1 | Noise-floor load pulse |
| nf_start_o | output | 1 | Noise-floor start pulse |
| done_o | output | 1 | Chain complete level |
| valid_mask_o | output | TYPE_W | Channel validity mask |

## Verification
The bench goes after the hand-over between jobs. A design that let the done level rise there would show fewer posts than expected at the moment done first goes high. A design that ignored the mask would be caught by a pre-set type bit, because the skipped job would still produce starts and collects. A target of zero would make a naive comparator wrap and run for many samples. Collecting in the same cycle a start is launched would add collects with no matching measurement. The bench also fires noise-floor ticks at random while jobs are in flight and checks that the load and start strobes follow each tick in order, one cycle apart.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [1:0] {
    JOB_WAIT = 2'd0,
    JOB_RUN  = 2'd1,
    JOB_DONE = 2'd2
  } job_st_e;
endpackage

// File: rtl/cal_seq_jobs.sv
module cal_seq_jobs import cal_seq_pkg::*; #(
  parameter int NUM_JOBS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     run_en_i,
  input  logic [IDX_W-1:0]         run_idx_i,
  input  logic                     done_en_i,
  input  logic [IDX_W-1:0]         done_idx_i,
  output logic [NUM_JOBS-1:0][1:0] st_o
);
  for (genvar g = 0; g < NUM_JOBS; g++) begin : g_job
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     st_o[g] <= JOB_WAIT;
      else if (clr_i)                                  st_o[g] <= JOB_WAIT;
      else if (run_en_i && run_idx_i == IDX_W'(g))     st_o[g] <= JOB_RUN;
      else if (done_en_i && done_idx_i == IDX_W'(g))   st_o[g] <= JOB_DONE;
    end

    // R6: a done job only leaves done through a clear
    assert_done_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(st_o[g]) == JOB_DONE && !$past(clr_i)) |-> st_o[g] == JOB_DONE);
  end
endmodule

// File: rtl/cal_seq_popcnt.sv
module cal_seq_popcnt #(
  parameter int W   = 3,
  parameter int C_W = 2
) (
  input  logic [W-1:0]   vec_i,
  output logic [C_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + C_W'(vec_i[i]);
  end
endmodule

// File: rtl/cal_seq_nf.sv
module cal_seq_nf (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic load_o,
  output logic start_o
);
  logic tick_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= 1'b0;
      load_o  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      tick_q  <= tick_i;
      load_o  <= tick_i & ~tick_q;
      start_o <= load_o;
    end
  end

  assert_nf_order_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(load_o));
  assert_nf_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

// File: rtl/cal_list_seq.sv
module cal_list_seq import cal_seq_pkg::*; #(
  parameter int NUM_JOBS = 4,
  parameter int TYPE_W   = 4,
  parameter int CNT_W    = 4,
  parameter int CHAINS   = 3,
  localparam int IDX_W   = (NUM_JOBS > 1) ? $clog2(NUM_JOBS) : 1,
  localparam int CHW     = $clog2(CHAINS + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          init_i,
  input  logic [IDX_W-1:0]              head_i,
  input  logic                          list_en_i,
  input  logic [TYPE_W-1:0]             chan_valid_i,
  input  logic [NUM_JOBS-1:0][TYPE_W-1:0] job_type_i,
  input  logic [NUM_JOBS-1:0][CNT_W-1:0]  job_target_i,
  input  logic [NUM_JOBS-1:0][IDX_W-1:0]  job_next_i,
  input  logic                          engine_busy_i,
  input  logic [CHAINS-1:0]             rx_mask_i,
  input  logic                          nf_tick_i,
  output logic                          start_o,
  output logic                          collect_o,
  output logic                          post_o,
  output logic [CHW-1:0]                post_chains_o,
  output logic                          nf_load_o,
  output logic                          nf_start_o,
  output logic                          done_o,
  output logic [TYPE_W-1:0]             valid_mask_o
);
  logic [NUM_JOBS-1:0][1:0] job_st;
  logic [IDX_W-1:0]  cur_idx_q, nxt_idx, run_idx;
  logic              cur_vld_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TYPE_W-1:0] valid_d, cur_type, nxt_type;
  logic [CNT_W:0]    cnt_inc, tgt_eff;
  logic [CHW-1:0]    chain_cnt;
  job_st_e           cur_st, nxt_st;
  logic do_start, do_collect, do_post, fin, skip, run_en, clr_cnt;

  cal_seq_jobs #(.NUM_JOBS(NUM_JOBS), .IDX_W(IDX_W)) u_jobs (
    .clk_i, .rst_ni, .clr_i(init_i),
    .run_en_i(run_en), .run_idx_i(run_idx),
    .done_en_i(fin | skip), .done_idx_i(cur_idx_q),
    .st_o(job_st)
  );

  cal_seq_popcnt #(.W(CHAINS), .C_W(CHW)) u_pop (.vec_i(rx_mask_i), .cnt_o(chain_cnt));

  cal_seq_nf u_nf (.clk_i, .rst_ni, .tick_i(nf_tick_i), .load_o(nf_load_o), .start_o(nf_start_o));

  assign cur_st   = job_st_e'(job_st[cur_idx_q]);
  assign cur_type = job_type_i[cur_idx_q];
  assign nxt_idx  = job_next_i[cur_idx_q];
  assign nxt_st   = job_st_e'(job_st[nxt_idx]);
  assign nxt_type = job_type_i[nxt_idx];
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign tgt_eff  = (job_target_i[cur_idx_q] == '0) ? (CNT_W+1)'(1) : {1'b0, job_target_i[cur_idx_q]};

  always_comb begin
    do_start = 1'b0; do_collect = 1'b0; do_post = 1'b0;
    fin = 1'b0; skip = 1'b0; run_en = 1'b0; clr_cnt = 1'b0;
    run_idx = cur_idx_q;
    if (cur_vld_q && !init_i) begin
      unique case (cur_st)
        JOB_RUN: if (!start_o && !engine_busy_i) begin
          do_collect = 1'b1;
          if (cnt_inc >= tgt_eff) begin
            do_post = 1'b1;
            fin     = 1'b1;
          end else begin
            do_start = 1'b1;
          end
        end
        JOB_WAIT: if ((valid_mask_o & cur_type) == '0) begin
          do_start = 1'b1; run_en = 1'b1; clr_cnt = 1'b1;
        end else begin
          skip = 1'b1;
        end
        default: ;
      endcase
    end
    valid_d = valid_mask_o | (do_post ? cur_type : '0);
    // hand-over: start the waiting successor in the same step
    if (fin && nxt_st == JOB_WAIT && (valid_d & nxt_type) == '0) begin
      do_start = 1'b1; run_en = 1'b1; clr_cnt = 1'b1; run_idx = nxt_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_idx_q <= '0; cur_vld_q <= 1'b0; cnt_q <= '0; valid_mask_o <= '0;
      start_o <= 1'b0; collect_o <= 1'b0; post_o <= 1'b0; post_chains_o <= '0;
    end else if (init_i) begin
      cur_idx_q <= head_i; cur_vld_q <= list_en_i; cnt_q <= '0; valid_mask_o <= chan_valid_i;
      start_o <= 1'b0; collect_o <= 1'b0; post_o <= 1'b0;
    end else begin
      start_o      <= do_start;
      collect_o    <= do_collect;
      post_o       <= do_post;
      valid_mask_o <= valid_d;
      if (do_post)         post_chains_o <= chain_cnt;
      if (clr_cnt)         cnt_q <= '0;
      else if (do_collect) cnt_q <= cnt_inc[CNT_W-1:0];
      if (fin || skip)     cur_idx_q <= nxt_idx;
    end
  end

  assign done_o = !cur_vld_q || cur_st == JOB_DONE;

  assert_collect_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collect_o |-> !$past(engine_busy_i) && !$past(start_o));
  assert_post_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_o |-> collect_o && post_chains_o == CHW'($countones($past(rx_mask_i))));
  assert_mask_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(init_i) |-> (valid_mask_o & $past(valid_mask_o)) == $past(valid_mask_o));
  assert_no_start_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cur_vld_q && !init_i) |=> !start_o);
  assert_start_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_collect_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collect_o |=> !collect_o);
  assert_post_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_o |=> !post_o);
endmodule

// File: tb/sim_cal_list_seq.sv
module sim_cal_list_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NJ = 4, TW = 4, CW = 4, CH = 3, IW = 2, PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_i = 1'b0, list_en = 1'b0, nf_tick = 1'b0, busy;
  logic [IW-1:0] head = '0;
  logic [TW-1:0] chan_valid = '0;
  logic [NJ-1:0][TW-1:0] jtype;
  logic [NJ-1:0][CW-1:0] jtgt = '0;
  logic [NJ-1:0][IW-1:0] jnext = '0;
  logic [CH-1:0] rx_mask = 3'b101;
  logic start_o, collect_o, post_o, nf_load_o, nf_start_o, done_o;
  logic [PW-1:0] post_chains;
  logic [TW-1:0] valid_mask;
  logic [2:0] bcnt;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_start = 0, n_coll = 0, n_post = 0, n_load = 0, n_nfs = 0;
  logic p_start = 0, p_coll = 0, p_post = 0, p_load = 0, p_nfs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_list_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init_i), .head_i(head), .list_en_i(list_en),
    .chan_valid_i(chan_valid), .job_type_i(jtype), .job_target_i(jtgt), .job_next_i(jnext),
    .engine_busy_i(busy), .rx_mask_i(rx_mask), .nf_tick_i(nf_tick),
    .start_o(start_o), .collect_o(collect_o), .post_o(post_o), .post_chains_o(post_chains),
    .nf_load_o(nf_load_o), .nf_start_o(nf_start_o), .done_o(done_o), .valid_mask_o(valid_mask)
  );

  for (genvar g = 0; g < NJ; g++) begin : g_type
    assign jtype[g] = TW'(1) << g;
  end

  // engine model: busy from the cycle after a start pulse, for 1..5 cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin busy <= 1'b0; bcnt <= '0; end
    else if (start_o) begin busy <= 1'b1; bcnt <= 3'($urandom_range(0, 4)); end
    else if (busy) begin
      if (bcnt == 0) busy <= 1'b0;
      else bcnt <= bcnt - 1'b1;
    end
  end

  function automatic int popc(logic [CH-1:0] v);
    int c = 0;
    for (int i = 0; i < CH; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      n_start += int'(start_o); n_coll += int'(collect_o); n_post += int'(post_o);
      n_load += int'(nf_load_o); n_nfs += int'(nf_start_o);
      if (post_o) chk("R5 post chain count", int'(post_chains), popc(rx_mask));
      if ((start_o && p_start) || (collect_o && p_coll) || (post_o && p_post) ||
          (nf_load_o && p_load) || (nf_start_o && p_nfs))
        chk("R11 pulse width", 2, 1);
      p_start = start_o; p_coll = collect_o; p_post = post_o; p_load = nf_load_o; p_nfs = nf_start_o;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic do_init(logic [IW-1:0] h, logic en, logic [TW-1:0] cv);
    @(negedge clk); #1;
    n_start = 0; n_coll = 0; n_post = 0; n_load = 0; n_nfs = 0;
    head = h; list_en = en; chan_valid = cv; init_i = 1'b1;
    @(negedge clk); #1;
    init_i = 1'b0;
    chk("R2 done after init", int'(done_o), int'(!en));
    chk("R2 mask loaded", int'(valid_mask), int'(cv));
  endtask

  // wait for done; optional random noise-floor ticks; returns ticks issued
  task automatic wait_done(bit ticks, output int nt);
    int gap = 10;
    nt = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      nf_tick = 1'b0;
      gap++;
      if (done_o) break;
      if (ticks && gap > 4 && $urandom_range(0, 7) == 0) begin
        nf_tick = 1'b1; gap = 0; nt++;
      end
    end
    nf_tick = 1'b0;
    if (!done_o) chk("R8 chain never completed", 0, 1);
  endtask

  // chain starting at h, each job i -> i+1, last one loops to itself
  task automatic set_chain(logic [IW-1:0] h);
    for (int k = 0; k < NJ; k++) begin
      int j = (int'(h) + k) % NJ;
      jnext[j] = (k == NJ - 1) ? IW'(j) : IW'((j + 1) % NJ);
    end
  endtask

  task automatic run_case(string tag, logic [IW-1:0] h, logic [TW-1:0] cv, bit ticks);
    int es = 0, ep = 0, nt;
    for (int j = 0; j < NJ; j++)
      if (!cv[j]) begin es += (jtgt[j] == 0) ? 1 : int'(jtgt[j]); ep++; end
    set_chain(h);
    do_init(h, 1'b1, cv);
    wait_done(ticks, nt);
    chk({tag, " R8 posts before done"}, n_post, ep);
    chk({tag, " R3 starts"}, n_start, es);
    chk({tag, " R4 collects"}, n_coll, es);
    chk({tag, " R6 mask"}, int'(valid_mask), (1 << TW) - 1);
    repeat (3) @(negedge clk);
    #1;
    chk({tag, " R9 idle no start"}, n_start, es);
    chk({tag, " R10 load count"}, n_load, nt);
    chk({tag, " R10 nf start count"}, n_nfs, nt);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 done", int'(done_o), 1);
    chk("R1 strobes", int'({start_o, collect_o, post_o, nf_load_o, nf_start_o}), 0);
    chk("R1 mask", int'(valid_mask), 0);
    rst_n = 1'b1;

    // R9: empty chain stays done and quiet
    do_init('0, 1'b0, '0);
    repeat (20) @(negedge clk);
    #1;
    chk("R9 empty done", int'(done_o), 1);
    chk("R9 empty starts", n_start, 0);

    // R10: tick timing
    @(negedge clk); #1; nf_tick = 1'b1;
    @(negedge clk); #1; nf_tick = 1'b0;
    chk("R10 load cycle", int'({nf_load_o, nf_start_o}), 2);
    @(negedge clk); #1;
    chk("R10 start cycle", int'({nf_load_o, nf_start_o}), 1);
    @(negedge clk); #1;
    chk("R11 nf quiet", int'({nf_load_o, nf_start_o}), 0);

    // directed: targets 2,1,3,0 (0 acts as 1)
    jtgt = {4'd0, 4'd3, 4'd1, 4'd2};
    rx_mask = 3'b101;
    run_case("full", 2'd0, 4'b0000, 1'b0);
    run_case("R7 skip job1", 2'd0, 4'b0010, 1'b0);
    run_case("R7 all valid", 2'd1, 4'b1111, 1'b0);

    // R5: single job with target 0 finishes after one sample
    jtgt = {4'd5, 4'd5, 4'd5, 4'd0};
    run_case("R5 zero target", 2'd0, 4'b1110, 1'b0);

    // random chains with noise-floor ticks in flight
    for (int it = 0; it < 25; it++) begin
      for (int j = 0; j < NJ; j++) jtgt[j] = CW'($urandom_range(0, 7));
      rx_mask = CH'($urandom_range(0, 7));
      run_case("rand", IW'($urandom_range(0, NJ - 1)), TW'($urandom_range(0, 15)), 1'b1);
    end

    finish_run();
  end
endmodule